// File: doc/BRIEF.md
# ASCII85 Line Word Decoder

This block converts a single line of ASCII85 text into 32-bit words. The text arrives one byte per handshake on a valid/ready input. Each decoded word leaves on an output port that has its own valid/ready pair. When the line has been fully consumed, the block raises a one-cycle completion pulse. Any indentation in front of the payload is dropped. The character `z` at the start of a group stands for a whole zero word. A newline closes the line, and if a group is only partly filled at that point, its raw accumulated value is emitted as the last word without any padding.

After a newline the decoder is ready for the next line and needs no further control. A sticky error flag records characters it could not use. It also records a line that does not open with a space. Only reset clears the flag.

Top module: `a85_line_decoder`

## Requirements
- R1: After reset, `out_valid`, `line_done` and `err` are 0 and `in_ready` is 1.
- R2: Spaces (0x20) before the payload are discarded and produce no word. If the first byte of a line is not a space, `err` is set, and decoding of that byte and the rest of the line still goes ahead.
- R3: A payload character in 0x21..0x75 updates the group value as value = value*85 + (char - 0x21), modulo 2^32. The value starts at 0 for each group. After five such characters, exactly one word carrying that value is emitted.
- R4: A `z` (0x7A) received while no group character is pending emits one word of 0. It does not affect the next group.
- R5: A newline (0x0A) that arrives while a group is partly filled emits the raw group value as a word, unpadded. `line_done` pulses in the cycle after that word is accepted.
- R6: A newline with no pending group emits no word. `line_done` pulses in the cycle after the newline is accepted.
- R7: A space inside the payload is ignored without error. Any other byte that is not a newline, not a payload character and not a `z` at a group boundary is ignored and sets `err`. This includes a `z` received in the middle of a group.
- R8: While `out_valid` is high and the word has not been accepted, `in_ready` is 0 and `out_word` holds its value.
- R9: `line_done` stays high for exactly one cycle, once per line. The next line then starts with an empty group and with indentation skipping active again.
- R10: Once `err` is set, it stays set until reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| in_data | input | 8 | Text byte |
| in_valid | input | 1 | `in_data` is offered |
| in_ready | output | 1 | Byte is taken at this edge when `in_valid` is high |
| out_word | output | WORD_W | Decoded word |
| out_valid | output | 1 | `out_word` is offered |
| out_ready | input | 1 | Consumer takes `out_word` |
| line_done | output | 1 | One-cycle pulse at the end of a line |
| err | output | 1 | Sticky flag for a bad character or a missing indent |

## Verification
The properties assume that the sender keeps to the input handshake, so a byte counts only on a cycle where `in_valid` and `in_ready` are both high. They also assume that reset is held for at least one clock edge. The stimulus always ends a line with a newline and waits for `line_done` before it starts the next line. Lines in the error-free phases draw only from spaces, payload characters and `z` at group boundaries. Bad bytes, a mid-group `z` and lines without indentation are sent only in a dedicated phase that comes before a reset. The consumer drops `out_ready` at random, so the hold behaviour under backpressure is exercised throughout.

// File: rtl/a85_pkg.sv
package a85_pkg;
   localparam logic [7:0] CH_SPACE = 8'h20;
   localparam logic [7:0] CH_NL    = 8'h0A;
   localparam logic [7:0] CH_ZERO  = 8'h7A;
   localparam logic [7:0] CH_LO    = 8'h21;
   localparam logic [7:0] CH_HI    = 8'h75;
   localparam int         RADIX    = 85;

   typedef enum logic [2:0] {
      CC_SPACE,
      CC_NL,
      CC_ZERO,
      CC_DIGIT,
      CC_BAD
   } char_class_t;
endpackage

// File: rtl/a85_char_class.sv
module a85_char_class
   import a85_pkg::*;
(
   input  logic [7:0]  ch,
   output char_class_t cls,
   output logic [7:0]  digit
);
   assign digit = ch - CH_LO;

   always_comb begin
      if (ch == CH_SPACE)
         cls = CC_SPACE;
      else if (ch == CH_NL)
         cls = CC_NL;
      else if (ch == CH_ZERO)
         cls = CC_ZERO;
      else if (ch >= CH_LO && ch <= CH_HI)
         cls = CC_DIGIT;
      else
         cls = CC_BAD;
   end
endmodule

// File: rtl/a85_group_acc.sv
module a85_group_acc
   import a85_pkg::*;
#(
   parameter int WORD_W        = 32,
   parameter int GROUP_LEN     = 5,
   parameter bit MUL_SHIFT_ADD = 1'b1,
   localparam int CNT_W        = $clog2(GROUP_LEN + 1)
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              step,
   input  logic              restart,
   input  logic [7:0]        digit,
   output logic [WORD_W-1:0] acc,
   output logic [WORD_W-1:0] acc_next,
   output logic [CNT_W-1:0]  cnt,
   output logic              at_last
);
   logic [WORD_W-1:0] scaled;

   generate
      if (MUL_SHIFT_ADD) begin : g_shift_add
         assign scaled = (acc << 6) + (acc << 4) + (acc << 2) + acc;
      end else begin : g_multiply
         assign scaled = acc * WORD_W'(RADIX);
      end
   endgenerate

   assign acc_next = scaled + {{(WORD_W-8){1'b0}}, digit};
   assign at_last  = (cnt == CNT_W'(GROUP_LEN - 1));

   always_ff @(posedge clk) begin
      if (!rst_n || restart) begin
         acc <= '0;
         cnt <= '0;
      end else if (step) begin
         acc <= acc_next;
         cnt <= cnt + 1'b1;
      end
   end
endmodule

// File: rtl/a85_line_decoder.sv
module a85_line_decoder
   import a85_pkg::*;
#(
   parameter int WORD_W        = 32,
   parameter int GROUP_LEN     = 5,
   parameter bit MUL_SHIFT_ADD = 1'b1,
   localparam int CNT_W        = $clog2(GROUP_LEN + 1)
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic [7:0]        in_data,
   input  logic              in_valid,
   output logic              in_ready,
   output logic [WORD_W-1:0] out_word,
   output logic              out_valid,
   input  logic              out_ready,
   output logic              line_done,
   output logic              err
);
   generate
      if (WORD_W < 16 || GROUP_LEN < 1 || GROUP_LEN > 8) begin : g_bad_cfg
         $error("a85_line_decoder: WORD_W must be >= 16 and GROUP_LEN in 1..8");
      end
   endgenerate

   char_class_t       cls;
   logic [7:0]        digit;
   logic [WORD_W-1:0] grp_acc;
   logic [WORD_W-1:0] grp_next;
   logic [CNT_W-1:0]  grp_cnt;
   logic              grp_last;
   logic              fire;
   logic              line_start;
   logic              tail_done;
   logic              step;
   logic              restart;

   assign in_ready = !out_valid;
   assign fire     = in_valid && in_ready;
   assign step     = fire && (cls == CC_DIGIT);
   assign restart  = fire && ((cls == CC_NL) || ((cls == CC_DIGIT) && grp_last));

   a85_char_class u_class (
      .ch    (in_data),
      .cls   (cls),
      .digit (digit)
   );

   a85_group_acc #(
      .WORD_W        (WORD_W),
      .GROUP_LEN     (GROUP_LEN),
      .MUL_SHIFT_ADD (MUL_SHIFT_ADD)
   ) u_acc (
      .clk      (clk),
      .rst_n    (rst_n),
      .step     (step),
      .restart  (restart),
      .digit    (digit),
      .acc      (grp_acc),
      .acc_next (grp_next),
      .cnt      (grp_cnt),
      .at_last  (grp_last)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         out_word   <= '0;
         out_valid  <= 1'b0;
         line_done  <= 1'b0;
         err        <= 1'b0;
         line_start <= 1'b1;
         tail_done  <= 1'b0;
      end else begin
         line_done <= 1'b0;
         if (out_valid && out_ready) begin
            out_valid <= 1'b0;
            if (tail_done) begin
               line_done <= 1'b1;
               tail_done <= 1'b0;
            end
         end
         if (fire) begin
            line_start <= 1'b0;
            if (line_start && cls != CC_SPACE)
               err <= 1'b1;
            case (cls)
               CC_NL: begin
                  line_start <= 1'b1;
                  if (grp_cnt != '0) begin
                     out_word  <= grp_acc;
                     out_valid <= 1'b1;
                     tail_done <= 1'b1;
                  end else begin
                     line_done <= 1'b1;
                  end
               end
               CC_ZERO: begin
                  if (grp_cnt == '0) begin
                     out_word  <= '0;
                     out_valid <= 1'b1;
                  end else begin
                     err <= 1'b1;
                  end
               end
               CC_DIGIT: begin
                  if (grp_last) begin
                     out_word  <= grp_next;
                     out_valid <= 1'b1;
                  end
               end
               CC_BAD:   err <= 1'b1;
               default:  ;
            endcase
         end
      end
   end
endmodule

// File: rtl/a85_line_decoder_chk.sv
module a85_line_decoder_chk #(
   parameter int WORD_W = 32,
   parameter int CNT_W  = 3
)(
   input logic              clk,
   input logic              rst_n,
   input logic [7:0]        in_data,
   input logic              in_valid,
   input logic              in_ready,
   input logic [WORD_W-1:0] out_word,
   input logic              out_valid,
   input logic              out_ready,
   input logic              line_done,
   input logic              err,
   input logic [CNT_W-1:0]  grp_cnt
);
   logic take;
   assign take = in_valid && in_ready;

   assert_no_take_while_full_R8: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> !in_ready) else $error("R8: input ready while word pending");

   assert_word_held_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !out_ready) |=> (out_valid && $stable(out_word)))
      else $error("R8: word changed under backpressure");

   assert_zero_word_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (take && in_data == 8'h7A && grp_cnt == '0) |=> (out_valid && out_word == '0))
      else $error("R4: zero shorthand did not yield zero word");

   assert_empty_newline_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (take && in_data == 8'h0A && grp_cnt == '0) |=> (line_done && !out_valid))
      else $error("R6: newline without group did not finish");

   assert_partial_flush_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (take && in_data == 8'h0A && grp_cnt != '0) |=> (out_valid && !line_done))
      else $error("R5: partial group not flushed before done");

   assert_done_after_word_R5: assert property (@(posedge clk) disable iff (!rst_n)
      line_done |-> !out_valid) else $error("R5: done while word pending");

   assert_done_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
      line_done |=> !line_done) else $error("R9: done longer than one cycle");

   assert_err_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
      err |=> err) else $error("R10: error flag cleared");
endmodule

bind a85_line_decoder a85_line_decoder_chk #(
   .WORD_W (WORD_W),
   .CNT_W  (CNT_W)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .in_data   (in_data),
   .in_valid  (in_valid),
   .in_ready  (in_ready),
   .out_word  (out_word),
   .out_valid (out_valid),
   .out_ready (out_ready),
   .line_done (line_done),
   .err       (err),
   .grp_cnt   (grp_cnt)
);

// File: tb/a85_line_decoder_test.sv
module a85_line_decoder_test;
   localparam int WORD_W = 32;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic [7:0]        in_data = 8'h00;
   logic              in_valid = 1'b0;
   logic              in_ready;
   logic [WORD_W-1:0] out_word;
   logic              out_valid;
   logic              out_ready;
   logic              line_done;
   logic              err;

   always #5 clk = ~clk;

   a85_line_decoder #(.WORD_W(WORD_W)) uut (
      .clk       (clk),
      .rst_n     (rst_n),
      .in_data   (in_data),
      .in_valid  (in_valid),
      .in_ready  (in_ready),
      .out_word  (out_word),
      .out_valid (out_valid),
      .out_ready (out_ready),
      .line_done (line_done),
      .err       (err)
   );

   int          n_checks = 0;
   int          n_fail   = 0;
   int          done_cnt = 0;
   logic [31:0] got_q[$];
   logic [31:0] exp_q[$];
   logic [7:0]  line_q[$];
   bit          exp_err = 1'b0;

   task automatic check(input bit ok, input string req, input string what,
                        input logic [31:0] act, input logic [31:0] expv);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual %h expected %h", req, what, act, expv);
      end
   endtask

   // output consumer and port monitor
   initial begin
      bit          bp;
      bit          prev_done;
      logic [31:0] held;
      bp = 1'b0; prev_done = 1'b0; held = '0;
      out_ready = 1'b0;
      forever begin
         @(negedge clk);
         out_ready = ($urandom_range(0, 9) < 7);
         #1;
         if (!rst_n) begin
            bp = 1'b0; prev_done = 1'b0;
         end else begin
            if (bp) check(out_valid && out_word == held, "R8", "held word", out_word, held);
            if (out_valid) check(!in_ready, "R8", "ready while word pending", {31'd0, in_ready}, 32'd0);
            bp   = out_valid && !out_ready;
            held = out_word;
            if (out_valid && out_ready) got_q.push_back(out_word);
            if (line_done) begin
               check(!prev_done, "R9", "done pulse width", 32'd1, 32'd0);
               done_cnt++;
            end
            prev_done = line_done;
         end
      end
   end

   // reference model built from the requirements
   task automatic model();
      logic [31:0] acc;
      int          cnt;
      bit          lead;
      exp_q.delete();
      acc = '0; cnt = 0; lead = 1'b1;
      if (line_q.size() > 0 && line_q[0] != 8'h20) exp_err = 1'b1;
      foreach (line_q[i]) begin
         logic [7:0] c;
         c = line_q[i];
         if (c == 8'h0A) begin
            if (cnt > 0) exp_q.push_back(acc);
            break;
         end else if (c == 8'h20) begin
            lead = lead;
         end else if (c == 8'h7A && cnt == 0) begin
            exp_q.push_back(32'd0);
         end else if (c >= 8'h21 && c <= 8'h75) begin
            acc = acc * 32'd85 + {24'd0, c - 8'h21};
            cnt++;
            if (cnt == 5) begin
               exp_q.push_back(acc);
               acc = '0; cnt = 0;
            end
         end else begin
            exp_err = 1'b1;
         end
      end
   endtask

   task automatic send_byte(input logic [7:0] b);
      if ($urandom_range(0, 3) == 0) repeat ($urandom_range(1, 3)) @(negedge clk);
      @(negedge clk); #2;
      in_valid = 1'b1;
      in_data  = b;
      while (!in_ready) begin
         @(negedge clk); #2;
      end
      @(posedge clk); #1;
      in_valid = 1'b0;
   endtask

   task automatic put(input string s);
      for (int i = 0; i < s.len(); i++) line_q.push_back(s[i]);
   endtask

   task automatic run_line(input string req);
      int base;
      base = done_cnt;
      got_q.delete();
      model();
      foreach (line_q[i]) send_byte(line_q[i]);
      while (done_cnt == base) @(negedge clk);
      repeat (3) @(negedge clk);
      check(done_cnt == base + 1, "R9", "one done per line", done_cnt, base + 1);
      check(got_q.size() == exp_q.size(), req, "word count", got_q.size(), exp_q.size());
      for (int i = 0; i < got_q.size() && i < exp_q.size(); i++)
         check(got_q[i] == exp_q[i], req, "word value", got_q[i], exp_q[i]);
      check(err == exp_err, "R10", "error flag", {31'd0, err}, {31'd0, exp_err});
   endtask

   task automatic rand_line();
      int ng;
      line_q.delete();
      repeat ($urandom_range(1, 3)) line_q.push_back(8'h20);
      ng = $urandom_range(0, 4);
      for (int g = 0; g < ng; g++) begin
         if ($urandom_range(0, 5) == 0) begin
            line_q.push_back(8'h7A);
         end else begin
            int len;
            len = (g == ng - 1) ? $urandom_range(1, 5) : 5;
            for (int k = 0; k < len; k++) begin
               if ($urandom_range(0, 9) == 0) line_q.push_back(8'h20);
               line_q.push_back(8'($urandom_range(8'h21, 8'h75)));
            end
         end
      end
      line_q.push_back(8'h0A);
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0;
      repeat (3) @(negedge clk);
      #1;
      check(in_ready && !out_valid && !line_done && !err, "R1", "reset state",
            {28'd0, in_ready, out_valid, line_done, err}, 32'h8);
      @(negedge clk);
      rst_n = 1'b1;
      exp_err = 1'b0;
   endtask

   initial begin
      void'($urandom(32'd20240611));
      do_reset();

      // R3: full group with known value
      line_q.delete(); put(" s8W-!\n"); run_line("R3");
      check(got_q.size() == 1 && got_q[0] == 32'hFFFF_FFFF, "R3", "all ones group",
            got_q.size() > 0 ? got_q[0] : 32'd0, 32'hFFFF_FFFF);
      // R2 R4: deep indent, zero group then shorthand
      line_q.delete(); put("   !!!!!z\n"); run_line("R4");
      // R5: partial group flushed raw
      line_q.delete(); put(" 87cU\n"); run_line("R5");
      check(got_q.size() == 1 && got_q[0] == 32'd14289487, "R5", "raw partial value",
            got_q.size() > 0 ? got_q[0] : 32'd0, 32'd14289487);
      // R6: empty line
      line_q.delete(); put(" \n"); run_line("R6");
      // R7: body spaces ignored without error
      line_q.delete(); put(" a b c d e\n"); run_line("R7");
      // R3: group truncation, two groups and zero between
      line_q.delete(); put("  uuuuuzuuuuu\n"); run_line("R3");
      // R9: next line starts fresh after a partial flush
      line_q.delete(); put(" Ab\n"); run_line("R9");
      line_q.delete(); put(" !!!!#\n"); run_line("R9");

      for (int n = 0; n < 40; n++) begin
         rand_line();
         run_line("R3");
      end

      // R7 R10: bad characters ignored, flag sticks
      line_q.delete(); put(" a~b\n"); run_line("R7");
      line_q.delete(); put(" abzcde\n"); run_line("R7");
      line_q.delete(); put(" !!!!!\n"); run_line("R10");
      // R2: missing indent flagged, content still decoded
      line_q.delete(); put("Q!!!!\n"); run_line("R2");

      do_reset();
      for (int n = 0; n < 6; n++) begin
         rand_line();
         run_line("R1");
      end

      $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      n_checks++;
      n_fail++;
      $display("FAIL R9 watchdog: actual %0d done pulses, expected run to finish", done_cnt);
      $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
   end
endmodule